// File: doc/BRIEF.md
# Fixed-Capacity Configurable-Width Single-Port SRAM

This block is a single-port synchronous memory whose storage is always exactly 16,384 bits. A build-time parameter picks the word width from 1, 2, 4, 8, 16 or 32 bits. The number of words changes to match, so capacity never changes: 16,384 words of 1 bit, down to 512 words of 32 bits. Word N at width W occupies array bits N*W up to N*W+W-1.

Every request input is captured on the active clock edge before it reaches the array. These inputs are the address, the write data, the write/read select and the two select lines. Capture happens only when the clock enable is active. The captured request is carried out on the following enabled edge. A read returns the word held before any write in that same access.

A parameter selects how read data leaves the block. It can pass through an output register, or it can be driven combinationally from the array at the captured address. Two active-low reset inputs are combined so that either one resets the block. The combined reset clears the capture and output registers at once. Its release is synchronised to the clock. The array contents survive reset. Two further parameters invert the clock and the clock enable.

Top module: `aspect_sram`

## Requirements
- R1: Depth is 16384/DATA_W words and the address is $clog2(16384/DATA_W) bits wide. Every word from address 0 to address depth-1, including both ends, stores and returns its own data independently of the others.
- R2: When the clock enable is active, an edge captures `addr`, `wdata`, `wr_en` and the select lines. The captured request is carried out at the next enabled edge.
- R3: An access happens only if `sel_a` and `sel_b` were both 1 when the request was captured. Any other request writes nothing, and in registered mode it leaves `rdata` unchanged.
- R4: While the effective clock enable is inactive, the captured request holds, no write takes place and `rdata` holds.
- R5: With RD_PATH = RD_REG, read data appears on `rdata` after the second enabled edge following the request: one edge captures it and one loads the output register. `rdata` keeps that value across cycles with no access.
- R6: With RD_PATH = RD_COMB, `rdata` shows the array word at the captured address directly after the capture edge.
- R7: A write access returns on `rdata` the word stored at that address before the write.
- R8: Reset is asserted when `arst_g_n` or `arst_l_n` is 0. It clears the capture registers and the output register to 0 at once, without a clock edge. The array contents are kept.
- R9: Reset release is synchronised. The block ignores requests on the first two clock edges after both reset inputs return to 1.
- R10: When CLK_INV = 1 the block acts on the falling edge of `clk`. When CE_INV = 1, `clk_en` is active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its polarity is set by CLK_INV |
| arst_g_n | input | 1 | Global asynchronous reset, active low |
| arst_l_n | input | 1 | Local asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; its polarity is set by CE_INV |
| sel_a | input | 1 | First select line |
| sel_b | input | 1 | Second select line |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |

## Verification
Assertions placed in the logic check four behaviours on every cycle: capture registers load when the enable is active, they hold when it is not, a request without both selects is captured as a non-access, and a completed write leaves the written word at its address. In registered mode they also check that the output register changes only on an access and then takes the pre-write array word. In combinational mode they check that the output is still while the enable is off.

Some behaviours show only across whole sequences, so only the bench scenarios demonstrate them. These are independent storage at both address ends and at two widths, the read-old result seen from outside, and requests with one select or a stalled enable that leave no trace. Also in this group: immediate clearing by either reset source with the array surviving, the two ignored edges after release, and identical behaviour on an inverted clock with an active-low enable.

// File: rtl/aspect_sram_pkg.sv
package aspect_sram_pkg;

  localparam int unsigned ARRAY_BITS = 16384;

  typedef enum logic {
    RD_COMB = 1'b0,
    RD_REG  = 1'b1
  } rd_path_e;

  function automatic bit width_legal(input int unsigned w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16) || (w == 32);
  endfunction

endpackage

// File: rtl/aspect_sram_rst_sync.sv
module aspect_sram_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign rst_n = stage_q[1];

endmodule

// File: rtl/aspect_sram_capture.sv
module aspect_sram_capture #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          wr_q,
  output logic          acc_q
);

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          wr;
    logic          acc;
  } req_t;

  req_t cur_q;
  req_t nxt;

  always_comb begin
    nxt = cur_q;
    if (ce) begin
      nxt.addr  = addr;
      nxt.wdata = wdata;
      nxt.wr    = wr_en;
      nxt.acc   = sel_a & sel_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign addr_q  = cur_q.addr;
  assign wdata_q = cur_q.wdata;
  assign wr_q    = cur_q.wr;
  assign acc_q   = cur_q.acc;

  // R2: an enabled edge loads the presented request
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (addr_q == $past(addr)) && (wdata_q == $past(wdata)) && (wr_q == $past(wr_en)));

  // R4: a disabled edge keeps the captured request
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(addr_q) && $stable(wdata_q) && $stable(wr_q) && $stable(acc_q));

  // R3: a request missing either select becomes a non-access
  p_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !(sel_a && sel_b)) |=> !acc_q);

endmodule

// File: rtl/aspect_sram_array.sv
module aspect_sram_array #(
  parameter int unsigned AW    = 11,
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_word
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_stb) mem[addr] <= wdata;
  end

  assign rd_word = mem[addr];

  // R1: a completed write leaves its data at its own word
  p_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> mem[$past(addr)] == $past(wdata));

endmodule

// File: rtl/aspect_sram_outreg.sv
module aspect_sram_outreg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] dout_q;
  logic [DW-1:0] dout_d;

  always_comb begin
    dout_d = dout_q;
    if (rd_stb) dout_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

  // R5: the output changes only on an access
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(dout));

  // R7: an access returns the word present before that edge's write
  p_readold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> dout == $past(word));

endmodule

// File: rtl/aspect_sram.sv
module aspect_sram #(
  parameter int unsigned              DATA_W  = 8,
  parameter aspect_sram_pkg::rd_path_e RD_PATH = aspect_sram_pkg::RD_REG,
  parameter bit                       CLK_INV = 1'b0,
  parameter bit                       CE_INV  = 1'b0,
  localparam int unsigned             DEPTH   = aspect_sram_pkg::ARRAY_BITS / DATA_W,
  localparam int unsigned             ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              arst_g_n,
  input  logic              arst_l_n,
  input  logic              clk_en,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  if (!aspect_sram_pkg::width_legal(DATA_W)) begin : g_bad_width
    $error("aspect_sram: DATA_W must be 1, 2, 4, 8, 16 or 32");
  end

  logic              clk_eff;
  logic              ce_eff;
  logic              arst_n;
  logic              rst_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic              acc_q;
  logic              wr_stb;
  logic [DATA_W-1:0] rd_word;

  if (CLK_INV) begin : g_clk_inv
    assign clk_eff = ~clk;
  end else begin : g_clk_dir
    assign clk_eff = clk;
  end

  assign ce_eff = clk_en ^ CE_INV;
  assign arst_n = arst_g_n & arst_l_n;

  aspect_sram_rst_sync u_rst_sync (
    .clk    (clk_eff),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  aspect_sram_capture #(.AW(ADDR_W), .DW(DATA_W)) u_capture (
    .clk     (clk_eff),
    .rst_n   (rst_n),
    .ce      (ce_eff),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .wr_q    (wr_q),
    .acc_q   (acc_q)
  );

  assign wr_stb = ce_eff & acc_q & wr_q;

  aspect_sram_array #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk     (clk_eff),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .rd_word (rd_word)
  );

  if (RD_PATH == aspect_sram_pkg::RD_REG) begin : g_rd_reg
    logic rd_stb;
    assign rd_stb = ce_eff & acc_q;
    aspect_sram_outreg #(.DW(DATA_W)) u_outreg (
      .clk    (clk_eff),
      .rst_n  (rst_n),
      .rd_stb (rd_stb),
      .word   (rd_word),
      .dout   (rdata)
    );
  end else begin : g_rd_comb
    assign rdata = rd_word;

    // R6: with the enable off neither address nor contents move, so the output is still
    p_comb_still_r6: assert property (@(posedge clk_eff) disable iff (!rst_n)
      !ce_eff |=> $stable(rdata));
  end

endmodule

// File: tb/aspect_sram_bench.sv
module aspect_sram_bench;

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;
  logic        arst_g_n, arst_l_n, ce, sa, sb, wr;
  logic [10:0] addr;
  logic [31:0] wdata;
  logic [7:0]  rd_a;
  logic [31:0] rd_b;
  logic [7:0]  mod_a [2048];
  logic [31:0] mod_b [512];
  logic [31:0] last_a = '0;
  item_t       qa[$];
  item_t       qb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // x8, registered output, direct clock and enable
  aspect_sram #(.DATA_W(8), .RD_PATH(aspect_sram_pkg::RD_REG)) u_aspect_sram (
    .clk(clk), .arst_g_n(arst_g_n), .arst_l_n(arst_l_n), .clk_en(ce),
    .sel_a(sa), .sel_b(sb), .wr_en(wr), .addr(addr), .wdata(wdata[7:0]), .rdata(rd_a));

  // x32, combinational output, inverted clock fed ~clk, active-low enable (R10)
  aspect_sram #(.DATA_W(32), .RD_PATH(aspect_sram_pkg::RD_COMB), .CLK_INV(1'b1), .CE_INV(1'b1))
    u_aspect_sram_w32 (
    .clk(~clk), .arst_g_n(arst_g_n), .arst_l_n(arst_l_n), .clk_en(~ce),
    .sel_a(sa), .sel_b(sb), .wr_en(wr), .addr(addr[8:0]), .wdata(wdata), .rdata(rd_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit s0, input bit s1, input bit w, input int a,
                       input logic [31:0] d, input bit en);
    sa = s0; sb = s1; wr = w; addr = a[10:0]; wdata = d; ce = en;
  endtask

  task automatic op(input bit s0, input bit s1, input bit w, input int a,
                    input logic [31:0] d, input bit en, input string tag);
    item_t ia, ib;
    @(negedge clk);
    drive(s0, s1, w, a, d, en);
    if (en) begin
      ia.due = cyc + 2;
      ia.exp = (s0 && s1) ? {24'b0, mod_a[a[10:0]]} : last_a;
      ia.tag = {tag, " x8 reg"};
      last_a = ia.exp;
      qa.push_back(ia);
      ib.due = cyc + 1;
      ib.exp = mod_b[a[8:0]];
      ib.tag = {tag, " x32 comb R10"};
      qb.push_back(ib);
      if (s0 && s1 && w) begin
        mod_a[a[10:0]] = d[7:0];
        mod_b[a[8:0]]  = d;
      end
    end
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 1'b0, 0, 32'h0, 1'b1, "R5 idle");
  endtask

  task automatic drain();
    while (qa.size() > 0 || qb.size() > 0) begin
      @(negedge clk);
      #1;
    end
  endtask

  // monitor: pop expectations as their sample cycle arrives
  always @(negedge clk) begin
    item_t it;
    while (qa.size() > 0 && qa[0].due <= cyc) begin
      it = qa.pop_front();
      chk(it.tag, {24'b0, rd_a}, it.exp);
    end
    while (qb.size() > 0 && qb[0].due <= cyc) begin
      it = qb.pop_front();
      chk(it.tag, rd_b, it.exp);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    arst_g_n = 1'b0;
    arst_l_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 0, 32'h0, 1'b1);
    repeat (3) @(negedge clk);
    #1 chk("R8 reset state", {24'b0, rd_a}, 32'h0);
    @(negedge clk);
    arst_g_n = 1'b1;
    arst_l_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: both address ends and a spread of words
    op(1, 1, 1, 0,    32'hA5C3_0F01, 1, "R1 write low");
    op(1, 1, 1, 2047, 32'h1234_5678, 1, "R1 write high");
    for (int i = 1; i <= 10; i++)
      op(1, 1, 1, (i * 131) % 2048, (i * 32'h0101_0101) ^ 32'h9E37_79B9, 1, "R2 write");
    op(1, 1, 0, 0,    32'h0, 1, "R1 read low");
    op(1, 1, 0, 2047, 32'h0, 1, "R1 read high");
    for (int i = 1; i <= 10; i++)
      op(1, 1, 0, (i * 131) % 2048, 32'h0, 1, "R2 R6 read");

    // R7: write returns prior contents, then new contents read back
    op(1, 1, 1, 0, 32'h5A5A_5A5A, 1, "R7 read-old");
    op(1, 1, 0, 0, 32'h0, 1, "R7 read-new");

    // R3: one select alone neither writes nor changes registered output
    op(1, 0, 1, 2047, 32'hFFFF_FFFF, 1, "R3 sel_a only");
    op(0, 1, 1, 2047, 32'hEEEE_EEEE, 1, "R3 sel_b only");
    op(1, 1, 0, 2047, 32'h0, 1, "R3 unchanged");

    // R5: registered output holds over idle cycles
    op(1, 1, 0, 131, 32'h0, 1, "R5 read");
    idle();
    idle();

    // R4: stalled enable blocks a write
    idle();
    op(1, 1, 1, 131, 32'hDEAD_BEEF, 0, "R4 stalled");
    op(1, 1, 1, 131, 32'hDEAD_BEEF, 0, "R4 stalled");
    idle();
    op(1, 1, 0, 131, 32'h0, 1, "R4 unchanged");

    // R8 / R9: local reset mid-run, array survives, early edges ignored
    op(1, 1, 1, 5, 32'h0000_0011, 1, "R8 write");
    idle();
    idle();
    drain();
    @(negedge clk);
    arst_l_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 0, 32'h0, 1'b1);
    #1 chk("R8 async clear", {24'b0, rd_a}, 32'h0);
    repeat (2) @(negedge clk);
    #1 chk("R8 held in reset", {24'b0, rd_a}, 32'h0);
    @(negedge clk);
    arst_l_n = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 5, 32'h0000_0022, 1'b1);
    @(negedge clk);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 0, 32'h0, 1'b1);
    #1 chk("R9 output still clear", {24'b0, rd_a}, 32'h0);
    last_a = '0;
    repeat (2) @(negedge clk);
    op(1, 1, 0, 5, 32'h0, 1, "R8 R9 kept");
    idle();
    idle();
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule